// File: doc/BRIEF.md
# Word-Serial Cipher Register Bank

This block is the bus-facing register front-end of a block-cipher engine. It holds one 128-bit data block and one 256-bit key, each stored as 32-bit words. Software or a DMA engine loads and unloads them one word per bus access. Every access to a word group moves that group by one position. Written words enter at the most significant position. Reads take the word at the least significant position and rotate it back in at the top, so four reads return the block and leave the contents unchanged.

The two key halves each form their own group. Each half answers at a window of aliased addresses. The low-half window sits directly below the high-half window, so a DMA sweep with an incrementing address writes the full 256-bit key in eight words. A second data address folds each incoming word into the stored block through XOR instead of overwriting it.

With a 128-bit key, a key-buffer option copies the high key half into the low half whenever an operation starts. The engine consumes the low half and turns it into a round key, so this option saves a key reload for every block. The engine itself lies outside this block. It is represented by a start strobe, a busy flag and a parallel result load.

Top module: `cipher_wordbank`

## Requirements
- R1: After reset every data and key word is zero and the read data port is zero.
- R2: A write to the data address (word address 0) shifts the data block one word toward the least significant end and places the written word at the most significant word. After four writes, the first word written is the least significant word.
- R3: A read from the data address returns the least significant data word on `bus_rdata` one cycle later. In the same clock edge that word is rotated into the most significant position, so four reads restore the block.
- R4: A write to the XOR-data address (word address 1) shifts the data block like R2. The value entering the most significant word is the bus word XORed with the least significant word being shifted out.
- R5: A read from the XOR-data address behaves exactly like a read from the data address (R3).
- R6: Word addresses 4 to 7 all access the low key half and 8 to 11 all access the high key half. Each half shifts and rotates as in R2 and R3, independently of the other half and of the data block. A write sweep over addresses 4 to 11 leaves the first word in the lowest key word and the last word in the highest key word.
- R7: When an operation starts with a 128-bit key (`key256_mode` low) and `keybuf_en` high, the low key half is loaded with a copy of the high key half on that edge. With `key256_mode` high or `keybuf_en` low, a start leaves the key unchanged.
- R8: While `eng_busy` is high, bus writes change no data or key word, and bus reads return zero and shift nothing.
- R9: An access to any other address changes no word, and the read data port is zero in every cycle that does not follow an accepted data or key read.
- R10: `eng_start` is high exactly when `op_start` is high and `eng_busy` is low. When `eng_done` is high while `eng_busy` is high, the data block and the whole key are loaded from `eng_data_in` and `eng_key_in`. The low key half occupies the low 128 bits of `eng_key_in`.
- R11: A bus access in the same cycle as an accepted `op_start` is ignored: it writes nothing, and a read returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Bus access in this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Word address |
| bus_wdata | input | 32 | Write word |
| bus_rdata | output | 32 | Read word, registered |
| key256_mode | input | 1 | 1 = 256-bit key, 0 = 128-bit key |
| keybuf_en | input | 1 | Key-restore on start enable |
| op_start | input | 1 | Request to start the engine |
| eng_busy | input | 1 | Engine is running |
| eng_done | input | 1 | Engine result load strobe |
| eng_data_in | input | 128 | Result block from the engine |
| eng_key_in | input | 256 | Key words returned by the engine |
| eng_start | output | 1 | Start strobe to the engine |
| data_blk | output | 128 | Data block, most significant word on top |
| key_blk | output | 256 | Key, low half in bits 127:0 |

## Verification
The checker watches every cycle for several properties. It checks that a busy engine freezes both word arrays and forces reads to zero. It checks that each accepted data read returns the bottom word and rotates it to the top, and that each XOR write places the bus word XORed with the outgoing bottom word at the top. It also checks the key restore on start, the engine result load and the idle-zero read port. Other behaviours can only be shown by the bench's scenarios. These are the full order of a four-word fill, the aliased key windows with an incrementing DMA sweep, the independence of the two key halves, and the absence of any restore in 256-bit mode or with the buffer disabled. The same holds for the silence of unmapped addresses and of accesses that coincide with a start.

// File: rtl/cwb_pkg.sv
package cwb_pkg;
   typedef enum logic [2:0] {
      ACC_NONE  = 3'd0,
      ACC_DATA  = 3'd1,
      ACC_XDATA = 3'd2,
      ACC_KEYLO = 3'd3,
      ACC_KEYHI = 3'd4
   } acc_e;

   function automatic bit is_data_kind(acc_e k);
      return (k == ACC_DATA) || (k == ACC_XDATA);
   endfunction
endpackage

// File: rtl/cwb_decode.sv
module cwb_decode
   import cwb_pkg::*;
#(
   parameter int ADDR_W     = 4,
   parameter int DATA_ADDR  = 0,
   parameter int XDATA_ADDR = 1,
   parameter int KEYLO_BASE = 4,
   parameter int KEYHI_BASE = 8,
   parameter int ALIAS_N    = 4
) (
   input  logic [ADDR_W-1:0] addr,
   output acc_e              kind
);
   localparam int SPAN = 1 << ADDR_W;

   generate
      if (KEYLO_BASE + ALIAS_N > SPAN || KEYHI_BASE + ALIAS_N > SPAN)
         begin : g_bad_span
            $error("key alias window exceeds address space");
         end
      if (KEYLO_BASE + ALIAS_N > KEYHI_BASE && KEYHI_BASE + ALIAS_N > KEYLO_BASE)
         begin : g_bad_overlap
            $error("key alias windows overlap");
         end
   endgenerate

   logic [ALIAS_N-1:0] lo_hit;
   logic [ALIAS_N-1:0] hi_hit;

   for (genvar a = 0; a < ALIAS_N; a++) begin : g_alias
      assign lo_hit[a] = (addr == ADDR_W'(KEYLO_BASE + a));
      assign hi_hit[a] = (addr == ADDR_W'(KEYHI_BASE + a));
   end

   always_comb begin
      if (addr == ADDR_W'(DATA_ADDR))       kind = ACC_DATA;
      else if (addr == ADDR_W'(XDATA_ADDR)) kind = ACC_XDATA;
      else if (|lo_hit)                     kind = ACC_KEYLO;
      else if (|hi_hit)                     kind = ACC_KEYHI;
      else                                  kind = ACC_NONE;
   end
endmodule

// File: rtl/cwb_shiftq.sv
module cwb_shiftq #(
   parameter int WORD_W = 32,
   parameter int DEPTH  = 4,
   parameter bit XOR_EN = 1'b0
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      load_en,
   input  logic [DEPTH*WORD_W-1:0]   load_val,
   input  logic                      wr_en,
   input  logic                      wr_xor,
   input  logic                      rd_en,
   input  logic [WORD_W-1:0]         wdata,
   output logic [WORD_W-1:0]         head,
   output logic [DEPTH*WORD_W-1:0]   words
);
   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("queue depth must be at least 2");
      end
   endgenerate

   logic [WORD_W-1:0] q [DEPTH];
   logic [WORD_W-1:0] top_in;
   logic [WORD_W-1:0] enter;
   logic              shift;

   generate
      if (XOR_EN) begin : g_xor
         assign top_in = wr_xor ? (wdata ^ q[0]) : wdata;
      end else begin : g_plain
         logic unused_xor;
         assign unused_xor = wr_xor;
         assign top_in     = wdata;
      end
   endgenerate

   assign shift = wr_en | rd_en;
   assign enter = wr_en ? top_in : q[0];

   for (genvar i = 0; i < DEPTH; i++) begin : g_word
      logic [WORD_W-1:0] nxt;
      if (i == DEPTH - 1) begin : g_top
         assign nxt = enter;
      end else begin : g_mid
         assign nxt = q[i+1];
      end

      always_ff @(posedge clk) begin
         if (!rst_n)       q[i] <= '0;
         else if (load_en) q[i] <= load_val[i*WORD_W +: WORD_W];
         else if (shift)   q[i] <= nxt;
      end

      assign words[i*WORD_W +: WORD_W] = q[i];
   end

   assign head = q[0];
endmodule

// File: rtl/cipher_wordbank.sv
module cipher_wordbank
   import cwb_pkg::*;
#(
   parameter int WORD_W     = 32,
   parameter int NWORDS     = 4,
   parameter int ADDR_W     = 4,
   parameter int DATA_ADDR  = 0,
   parameter int XDATA_ADDR = 1,
   parameter int KEYLO_BASE = 4,
   parameter int KEYHI_BASE = 8,
   parameter int ALIAS_N    = 4,
   parameter bit KEYBUF_OPT = 1'b1
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         bus_valid,
   input  logic                         bus_write,
   input  logic [ADDR_W-1:0]            bus_addr,
   input  logic [WORD_W-1:0]            bus_wdata,
   output logic [WORD_W-1:0]            bus_rdata,
   input  logic                         key256_mode,
   input  logic                         keybuf_en,
   input  logic                         op_start,
   input  logic                         eng_busy,
   input  logic                         eng_done,
   input  logic [WORD_W*NWORDS-1:0]     eng_data_in,
   input  logic [2*WORD_W*NWORDS-1:0]   eng_key_in,
   output logic                         eng_start,
   output logic [WORD_W*NWORDS-1:0]     data_blk,
   output logic [2*WORD_W*NWORDS-1:0]   key_blk
);
   localparam int BLK_W = WORD_W * NWORDS;
   localparam int KEY_W = 2 * BLK_W;

   generate
      if (WORD_W < 8) begin : g_bad_word
         $error("word width too small");
      end
      if (DATA_ADDR == XDATA_ADDR) begin : g_bad_data
         $error("data and xor-data addresses must differ");
      end
   endgenerate

   acc_e kind;

   cwb_decode #(
      .ADDR_W(ADDR_W), .DATA_ADDR(DATA_ADDR), .XDATA_ADDR(XDATA_ADDR),
      .KEYLO_BASE(KEYLO_BASE), .KEYHI_BASE(KEYHI_BASE), .ALIAS_N(ALIAS_N)
   ) u_dec (
      .addr (bus_addr),
      .kind (kind)
   );

   logic start_ok, acc_ok, wr_ok, rd_ok, done_ok, restore;

   assign start_ok = op_start & ~eng_busy;
   assign acc_ok   = bus_valid & ~eng_busy & ~op_start;
   assign wr_ok    = acc_ok & bus_write;
   assign rd_ok    = acc_ok & ~bus_write;
   assign done_ok  = eng_done & eng_busy;
   assign eng_start = start_ok;

   generate
      if (KEYBUF_OPT) begin : g_keybuf
         assign restore = start_ok & ~key256_mode & keybuf_en;
      end else begin : g_nokeybuf
         logic unused_cfg;
         assign unused_cfg = key256_mode ^ keybuf_en;
         assign restore    = 1'b0;
      end
   endgenerate

   logic [WORD_W-1:0] data_head, klo_head, khi_head;
   logic [BLK_W-1:0]  klo_words, khi_words, klo_load;

   cwb_shiftq #(.WORD_W(WORD_W), .DEPTH(NWORDS), .XOR_EN(1'b1)) u_data (
      .clk      (clk),
      .rst_n    (rst_n),
      .load_en  (done_ok),
      .load_val (eng_data_in),
      .wr_en    (wr_ok & is_data_kind(kind)),
      .wr_xor   (kind == ACC_XDATA),
      .rd_en    (rd_ok & is_data_kind(kind)),
      .wdata    (bus_wdata),
      .head     (data_head),
      .words    (data_blk)
   );

   assign klo_load = restore ? khi_words : eng_key_in[BLK_W-1:0];

   cwb_shiftq #(.WORD_W(WORD_W), .DEPTH(NWORDS), .XOR_EN(1'b0)) u_keylo (
      .clk      (clk),
      .rst_n    (rst_n),
      .load_en  (done_ok | restore),
      .load_val (klo_load),
      .wr_en    (wr_ok & (kind == ACC_KEYLO)),
      .wr_xor   (1'b0),
      .rd_en    (rd_ok & (kind == ACC_KEYLO)),
      .wdata    (bus_wdata),
      .head     (klo_head),
      .words    (klo_words)
   );

   cwb_shiftq #(.WORD_W(WORD_W), .DEPTH(NWORDS), .XOR_EN(1'b0)) u_keyhi (
      .clk      (clk),
      .rst_n    (rst_n),
      .load_en  (done_ok),
      .load_val (eng_key_in[KEY_W-1:BLK_W]),
      .wr_en    (wr_ok & (kind == ACC_KEYHI)),
      .wr_xor   (1'b0),
      .rd_en    (rd_ok & (kind == ACC_KEYHI)),
      .wdata    (bus_wdata),
      .head     (khi_head),
      .words    (khi_words)
   );

   assign key_blk = {khi_words, klo_words};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         bus_rdata <= '0;
      end else begin
         bus_rdata <= '0;
         if (rd_ok) begin
            unique case (kind)
               ACC_DATA, ACC_XDATA: bus_rdata <= data_head;
               ACC_KEYLO:           bus_rdata <= klo_head;
               ACC_KEYHI:           bus_rdata <= khi_head;
               default:             bus_rdata <= '0;
            endcase
         end
      end
   end
endmodule

// File: rtl/cwb_checker.sv
module cwb_checker #(
   parameter int WORD_W     = 32,
   parameter int NWORDS     = 4,
   parameter int ADDR_W     = 4,
   parameter int DATA_ADDR  = 0,
   parameter int XDATA_ADDR = 1,
   parameter bit KEYBUF_OPT = 1'b1
) (
   input logic                         clk,
   input logic                         rst_n,
   input logic                         bus_valid,
   input logic                         bus_write,
   input logic [ADDR_W-1:0]            bus_addr,
   input logic [WORD_W-1:0]            bus_wdata,
   input logic [WORD_W-1:0]            bus_rdata,
   input logic                         key256_mode,
   input logic                         keybuf_en,
   input logic                         op_start,
   input logic                         eng_busy,
   input logic                         eng_done,
   input logic [WORD_W*NWORDS-1:0]     eng_data_in,
   input logic [2*WORD_W*NWORDS-1:0]   eng_key_in,
   input logic                         eng_start,
   input logic [WORD_W*NWORDS-1:0]     data_blk,
   input logic [2*WORD_W*NWORDS-1:0]   key_blk
);
   localparam int BLK_W = WORD_W * NWORDS;
   localparam int KEY_W = 2 * BLK_W;

   logic open_acc, at_data, at_xdata;
   assign open_acc = bus_valid && !eng_busy && !op_start;
   assign at_data  = (bus_addr == ADDR_W'(DATA_ADDR));
   assign at_xdata = (bus_addr == ADDR_W'(XDATA_ADDR));

   AST_BUSY_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
      (eng_busy && !eng_done) |=> ($stable(data_blk) && $stable(key_blk))); // R8

   AST_BUSY_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_valid && !bus_write && eng_busy) |=> (bus_rdata == '0)); // R8

   AST_DATA_READ_ROTATE: assert property (@(posedge clk) disable iff (!rst_n)
      (open_acc && !bus_write && (at_data || at_xdata)) |=>
         ((bus_rdata == $past(data_blk[WORD_W-1:0])) &&
          (data_blk == {$past(data_blk[WORD_W-1:0]), $past(data_blk[BLK_W-1:WORD_W])}))); // R3

   AST_XOR_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (open_acc && bus_write && at_xdata) |=>
         (data_blk[BLK_W-1 -: WORD_W] == $past(bus_wdata ^ data_blk[WORD_W-1:0]))); // R4

   AST_KEY_RESTORE: assert property (@(posedge clk) disable iff (!rst_n)
      (KEYBUF_OPT && op_start && !eng_busy && !key256_mode && keybuf_en) |=>
         (key_blk[BLK_W-1:0] == $past(key_blk[KEY_W-1:BLK_W]))); // R7

   AST_DONE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (eng_done && eng_busy) |=>
         ((data_blk == $past(eng_data_in)) && (key_blk == $past(eng_key_in)))); // R10

   AST_START_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      eng_start |-> (op_start && !eng_busy)); // R10

   AST_IDLE_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_valid && !bus_write) |=> (bus_rdata == '0)); // R9
endmodule

bind cipher_wordbank cwb_checker #(
   .WORD_W(WORD_W), .NWORDS(NWORDS), .ADDR_W(ADDR_W),
   .DATA_ADDR(DATA_ADDR), .XDATA_ADDR(XDATA_ADDR), .KEYBUF_OPT(KEYBUF_OPT)
) u_cwb_chk (
   .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
   .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
   .key256_mode(key256_mode), .keybuf_en(keybuf_en), .op_start(op_start),
   .eng_busy(eng_busy), .eng_done(eng_done), .eng_data_in(eng_data_in),
   .eng_key_in(eng_key_in), .eng_start(eng_start), .data_blk(data_blk),
   .key_blk(key_blk)
);

// File: tb/cipher_wordbank_test.sv
module cipher_wordbank_test;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         bus_valid = 1'b0, bus_write = 1'b0;
   logic [3:0]   bus_addr = '0;
   logic [31:0]  bus_wdata = '0;
   logic [31:0]  bus_rdata;
   logic         key256_mode = 1'b0, keybuf_en = 1'b0, op_start = 1'b0;
   logic         eng_busy = 1'b0, eng_done = 1'b0;
   logic [127:0] eng_data_in = '0;
   logic [255:0] eng_key_in = '0;
   logic         eng_start;
   logic [127:0] data_blk;
   logic [255:0] key_blk;

   int checks = 0;
   int errors = 0;

   always #10 clk = ~clk;

   cipher_wordbank uut (
      .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .key256_mode(key256_mode), .keybuf_en(keybuf_en), .op_start(op_start),
      .eng_busy(eng_busy), .eng_done(eng_done), .eng_data_in(eng_data_in),
      .eng_key_in(eng_key_in), .eng_start(eng_start), .data_blk(data_blk),
      .key_blk(key_blk)
   );

   // vector: {is_write, addr, wdata, expected read word}
   localparam logic [68:0] VEC [16] = '{
      {1'b1, 4'd0, 32'h1111_1111, 32'h0},
      {1'b1, 4'd0, 32'h2222_2222, 32'h0},
      {1'b1, 4'd0, 32'h3333_3333, 32'h0},
      {1'b1, 4'd0, 32'h4444_4444, 32'h0},
      {1'b0, 4'd0, 32'h0,         32'h1111_1111},
      {1'b0, 4'd1, 32'h0,         32'h2222_2222},
      {1'b0, 4'd0, 32'h0,         32'h3333_3333},
      {1'b0, 4'd0, 32'h0,         32'h4444_4444},
      {1'b1, 4'd1, 32'h0000_FFFF, 32'h0},
      {1'b1, 4'd1, 32'hFFFF_0000, 32'h0},
      {1'b1, 4'd1, 32'h0000_0000, 32'h0},
      {1'b1, 4'd1, 32'h4444_4444, 32'h0},
      {1'b0, 4'd0, 32'h0,         32'h1111_EEEE},
      {1'b0, 4'd1, 32'h0,         32'hDDDD_2222},
      {1'b0, 4'd0, 32'h0,         32'h3333_3333},
      {1'b0, 4'd0, 32'h0,         32'h0000_0000}
   };

   task automatic chk(input bit ok, input string req, input logic [255:0] act,
                      input logic [255:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s act=%h exp=%h", req, act, exp);
      end
   endtask

   task automatic summary();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
   endtask

   // one bus access; rdata is valid at the following falling edge
   task automatic bus(input bit wr, input logic [3:0] a, input logic [31:0] d,
                      output logic [31:0] rd);
      @(negedge clk);
      bus_valid = 1'b1; bus_write = wr; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_valid = 1'b0; bus_write = 1'b0;
      rd = bus_rdata;
   endtask

   task automatic start_pulse();
      @(negedge clk);
      op_start = 1'b1;
      @(negedge clk);
      op_start = 1'b0;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      errors++;
      $display("FAIL watchdog act=running exp=finished");
      summary();
      $finish;
   end

   initial begin
      logic [31:0] rd;
      logic [127:0] hold;
      logic [255:0] khold;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(data_blk == '0, "R1 data", {128'h0, data_blk}, '0);
      chk(key_blk == '0, "R1 key", key_blk, '0);
      chk(bus_rdata == '0, "R1 rdata", {224'h0, bus_rdata}, '0);

      // table: fill, rotate-read (R2 R3 R5), XOR fold (R4)
      for (int i = 0; i < 16; i++) begin
         bus(VEC[i][68], VEC[i][67:64], VEC[i][63:32], rd);
         if (!VEC[i][68])
            chk(rd == VEC[i][31:0], "R3/R5 read word", {224'h0, rd}, {224'h0, VEC[i][31:0]});
         if (i == 3)
            chk(data_blk == {32'h4444_4444, 32'h3333_3333, 32'h2222_2222, 32'h1111_1111},
                "R2 fill order", {128'h0, data_blk},
                {128'h0, 32'h4444_4444, 32'h3333_3333, 32'h2222_2222, 32'h1111_1111});
      end
      chk(data_blk == {32'h0, 32'h3333_3333, 32'hDDDD_2222, 32'h1111_EEEE},
          "R4 xor block", {128'h0, data_blk},
          {128'h0, 32'h0, 32'h3333_3333, 32'hDDDD_2222, 32'h1111_EEEE});

      // R6 key sweep over addresses 4..11
      for (int a = 4; a < 12; a++)
         bus(1'b1, 4'(a), (a < 8) ? 32'hA000_0000 + 32'(a - 4) : 32'hB000_0000 + 32'(a - 8), rd);
      khold = {32'hB000_0003, 32'hB000_0002, 32'hB000_0001, 32'hB000_0000,
               32'hA000_0003, 32'hA000_0002, 32'hA000_0001, 32'hA000_0000};
      chk(key_blk == khold, "R6 key sweep", key_blk, khold);
      chk(data_blk == {32'h0, 32'h3333_3333, 32'hDDDD_2222, 32'h1111_EEEE},
          "R6 data untouched", {128'h0, data_blk}, {128'h0, 32'h0, 32'h3333_3333, 32'hDDDD_2222, 32'h1111_EEEE});
      bus(1'b0, 4'd9, 32'h0, rd);
      chk(rd == 32'hB000_0000, "R6 high alias read", {224'h0, rd}, {224'h0, 32'hB000_0000});
      chk(key_blk == {32'hB000_0000, 32'hB000_0003, 32'hB000_0002, 32'hB000_0001, khold[127:0]},
          "R6 high rotate only", key_blk,
          {32'hB000_0000, 32'hB000_0003, 32'hB000_0002, 32'hB000_0001, khold[127:0]});
      bus(1'b0, 4'd11, 32'h0, rd);
      bus(1'b0, 4'd8, 32'h0, rd);
      bus(1'b0, 4'd10, 32'h0, rd);
      chk(rd == 32'hB000_0003, "R6 alias fourth read", {224'h0, rd}, {224'h0, 32'hB000_0003});
      chk(key_blk == khold, "R6 rotate restored", key_blk, khold);
      bus(1'b0, 4'd6, 32'h0, rd);
      chk(rd == 32'hA000_0000, "R6 low alias read", {224'h0, rd}, {224'h0, 32'hA000_0000});

      // R7 restore on start in 128-bit mode with buffer on
      bus(1'b1, 4'd4, 32'hDEAD_0000, rd);
      key256_mode = 1'b0; keybuf_en = 1'b1;
      @(negedge clk);
      op_start = 1'b1;
      #1;
      chk(eng_start == 1'b1, "R10 start strobe", {255'h0, eng_start}, 256'h1);
      @(negedge clk);
      op_start = 1'b0;
      chk(key_blk == {khold[255:128], khold[255:128]}, "R7 restore", key_blk,
          {khold[255:128], khold[255:128]});
      // no restore in 256-bit mode
      bus(1'b1, 4'd5, 32'hBEEF_0000, rd);
      khold = key_blk;
      key256_mode = 1'b1;
      start_pulse();
      chk(key_blk == khold, "R7 no restore 256", key_blk, khold);
      key256_mode = 1'b0; keybuf_en = 1'b0;
      start_pulse();
      chk(key_blk == khold, "R7 no restore buf off", key_blk, khold);

      // R11 bus access during start is dropped
      hold = data_blk;
      @(negedge clk);
      op_start = 1'b1; bus_valid = 1'b1; bus_write = 1'b1; bus_addr = 4'd0;
      bus_wdata = 32'h5A5A_5A5A;
      @(negedge clk);
      op_start = 1'b0; bus_valid = 1'b0; bus_write = 1'b0;
      chk(data_blk == hold, "R11 write in start", {128'h0, data_blk}, {128'h0, hold});
      @(negedge clk);
      op_start = 1'b1; bus_valid = 1'b1; bus_addr = 4'd0;
      @(negedge clk);
      op_start = 1'b0; bus_valid = 1'b0;
      chk(bus_rdata == '0, "R11 read in start", {224'h0, bus_rdata}, '0);

      // R8 busy
      eng_busy = 1'b1;
      khold = key_blk;
      bus(1'b1, 4'd0, 32'h7777_7777, rd);
      bus(1'b1, 4'd8, 32'h7777_7777, rd);
      chk(data_blk == hold, "R8 busy write data", {128'h0, data_blk}, {128'h0, hold});
      chk(key_blk == khold, "R8 busy write key", key_blk, khold);
      bus(1'b0, 4'd0, 32'h0, rd);
      chk(rd == '0, "R8 busy read zero", {224'h0, rd}, '0);
      chk(data_blk == hold, "R8 busy read no shift", {128'h0, data_blk}, {128'h0, hold});
      @(negedge clk);
      op_start = 1'b1;
      #1;
      chk(eng_start == 1'b0, "R10 no start when busy", {255'h0, eng_start}, '0);
      @(negedge clk);
      op_start = 1'b0;

      // R10 engine result load
      eng_data_in = {32'hC3, 32'hC2, 32'hC1, 32'hC0};
      eng_key_in  = {8{32'h0F0F_0000}} ^ 256'h1234;
      @(negedge clk);
      eng_done = 1'b1;
      @(negedge clk);
      eng_done = 1'b0; eng_busy = 1'b0;
      chk(data_blk == eng_data_in, "R10 data load", {128'h0, data_blk}, {128'h0, eng_data_in});
      chk(key_blk == eng_key_in, "R10 key load", key_blk, eng_key_in);
      bus(1'b0, 4'd1, 32'h0, rd);
      chk(rd == 32'hC0, "R5 xor addr read", {224'h0, rd}, {224'h0, 32'hC0});

      // R9 unmapped addresses
      hold = data_blk; khold = key_blk;
      bus(1'b1, 4'd15, 32'h9999_9999, rd);
      bus(1'b1, 4'd2, 32'h9999_9999, rd);
      chk(data_blk == hold && key_blk == khold, "R9 unmapped write", {128'h0, data_blk}, {128'h0, hold});
      bus(1'b0, 4'd12, 32'h0, rd);
      chk(rd == '0, "R9 unmapped read", {224'h0, rd}, '0);
      chk(data_blk == hold && key_blk == khold, "R9 unmapped read no shift", key_blk, khold);

      summary();
      $finish;
   end
endmodule